// File: doc/BRIEF.md
# Half-Rate Stepped Pseudo-Random Pattern Source

This block produces test vectors for a memory self-test engine. At its core is a three-stage shift register with linear feedback from the polynomial x^3 + x^2 + 1. A free-running register would walk through its seven non-zero states in seven clocks. Here an internal divide-by-two control signal allows a step only on every second enabled clock. As a result, every vector stays on the output for two consecutive enabled clocks, and the full sequence takes fourteen enabled clocks before it comes back to the seed.

A consumer samples `pat_o` on each clock where `pat_vld_o` is high. The edge at the end of that clock then moves the generator on. Dropping `run_en_i` freezes the whole generator (the shift register, the divide-by-two phase and the position in the period), so a memory test sequencer can stall it without losing its place. A synchronous reset reloads the seed. `eop_o` marks the last sample of every fourteen-sample period, so the sequencer can count passes.

Top module: `halfrate_lfsr_tpg`

## Requirements
- R1: While `rst_i` is high at a rising edge, the pattern is loaded with the seed 3'b100 (bit 2 = Q2, bit 0 = Q0), the divide-by-two phase is cleared and the period position returns to its start. After reset, `eop_o` is low and the pattern reads 3'b100.
- R2: A step shifts the register toward the high bit and feeds Q2 XOR Q1 into Q0. Starting from the seed, this gives the order 100, 001, 010, 101, 011, 111, 110, and then 100 again.
- R3: Each vector is presented on two consecutive enabled clocks. The first vector after reset is held for two enabled clocks, and a step happens only at the end of the second of the two.
- R4: One period spans exactly 14 enabled clocks. Within a period, each of the seven non-zero vectors appears exactly twice and the all-zero vector never appears.
- R5: `eop_o` is high on the 14th enabled clock of every period (the second sample of 3'b110) and low on all other clocks. On the next enabled clock the pattern reads the seed.
- R6: While `run_en_i` is low, the pattern, the divide-by-two phase and the period position all hold, and `eop_o` stays low. This applies even when the generator sits at the last position of a period.
- R7: `pat_vld_o` is high exactly when `run_en_i` is high and `rst_i` is low.
- R8: The pattern is never all zero. If the register is ever found at zero, the next edge reloads the seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_i | input | 1 | Synchronous active-high reset; loads the seed |
| run_en_i | input | 1 | Enables the generator for this clock |
| pat_o | output | 3 | Current test vector, Q2 in bit 2 |
| pat_vld_o | output | 1 | The vector on `pat_o` is a sample to consume this clock |
| eop_o | output | 1 | Last sample of the 14-sample period |

## Verification
The interesting collision is between the end-of-period marker and a stall. The enable can fall on the very clock where the generator sits at the last position of its period. The bench provokes this by dropping `run_en_i` exactly when its own model reaches position 13 and holding it low for several clocks. It expects `eop_o` to stay low and the pattern to stay at 3'b110 during the stall. When the enable returns, the scoreboard expects exactly one marker, followed by the seed with its two-clock hold intact.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } phase_e;

   // Number of enabled clocks in one full sequence of a maximal register.
   function automatic int unsigned seq_period(input int unsigned width, input bit half_rate);
      int unsigned states;
      states = (1 << width) - 1;
      return half_rate ? 2 * states : states;
   endfunction

   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/lfsr_core.sv
module lfsr_core #(
   parameter int unsigned   WIDTH = 3,
   parameter logic [WIDTH-1:0] SEED  = 3'b100,
   parameter logic [WIDTH-1:0] TAPS  = 3'b110
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             step_i,
   output logic [WIDTH-1:0] state_o
);

   logic [WIDTH-1:0] state_q;
   logic             fb;

   assign fb = ^(state_q & TAPS);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= SEED;
      end else if (state_q == '0) begin
         state_q <= SEED;
      end else if (step_i) begin
         state_q <= {state_q[WIDTH-2:0], fb};
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/rate_ctrl.sv
module rate_ctrl
   import tpg_pkg::*;
#(
   parameter bit HALF_RATE = 1'b1
) (
   input  logic   clk_i,
   input  logic   rst_i,
   input  logic   run_i,
   output logic   step_o,
   output phase_e phase_o
);

   generate
      if (HALF_RATE) begin : g_half
         phase_e phase_q;

         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               phase_q <= PH_FIRST;
            end else if (run_i) begin
               phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
            end
         end

         assign step_o  = run_i && (phase_q == PH_SECOND);
         assign phase_o = phase_q;
      end else begin : g_full
         assign step_o  = run_i;
         assign phase_o = PH_SECOND;
      end
   endgenerate

endmodule

// File: rtl/period_tracker.sv
module period_tracker #(
   parameter int unsigned PERIOD = 14,
   parameter int unsigned CNT_W  = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] pos_o,
   output logic             last_o
);

   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] pos_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pos_q <= '0;
      end else if (run_i) begin
         pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      end
   end

   assign pos_o  = pos_q;
   assign last_o = (pos_q == LAST_POS);

endmodule

// File: rtl/halfrate_lfsr_tpg.sv
module halfrate_lfsr_tpg
   import tpg_pkg::*;
#(
   parameter int unsigned      WIDTH     = 3,
   parameter logic [WIDTH-1:0] SEED      = 3'b100,
   parameter logic [WIDTH-1:0] TAPS      = 3'b110,
   parameter bit               HALF_RATE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             run_en_i,
   output logic [WIDTH-1:0] pat_o,
   output logic             pat_vld_o,
   output logic             eop_o
);

   localparam int unsigned PERIOD = seq_period(WIDTH, HALF_RATE);
   localparam int unsigned CNT_W  = cnt_bits(PERIOD);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("halfrate_lfsr_tpg: WIDTH must be at least 2");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("halfrate_lfsr_tpg: SEED must be non-zero");
      end
      if (!TAPS[WIDTH-1]) begin : g_bad_taps
         $error("halfrate_lfsr_tpg: TAPS must include the top stage");
      end
   endgenerate

   logic             step;
   phase_e           phase;
   logic [CNT_W-1:0] pos;
   logic             at_last;
   logic [WIDTH-1:0] state;

   rate_ctrl #(
      .HALF_RATE (HALF_RATE)
   ) u_rate (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .run_i   (run_en_i),
      .step_o  (step),
      .phase_o (phase)
   );

   lfsr_core #(
      .WIDTH (WIDTH),
      .SEED  (SEED),
      .TAPS  (TAPS)
   ) u_lfsr (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .step_i  (step),
      .state_o (state)
   );

   period_tracker #(
      .PERIOD (PERIOD),
      .CNT_W  (CNT_W)
   ) u_period (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .run_i  (run_en_i),
      .pos_o  (pos),
      .last_o (at_last)
   );

   assign pat_o     = state;
   assign pat_vld_o = run_en_i && !rst_i;
   assign eop_o     = run_en_i && !rst_i && at_last;

endmodule

// File: rtl/halfrate_lfsr_tpg_chk.sv
module halfrate_lfsr_tpg_chk #(
   parameter int unsigned      WIDTH     = 3,
   parameter logic [WIDTH-1:0] SEED      = 3'b100,
   parameter bit               HALF_RATE = 1'b1
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             run_en_i,
   input logic [WIDTH-1:0] pat_i,
   input logic             pat_vld_i,
   input logic             eop_i,
   input logic             phase_i
);

   // R1: first clock out of reset shows the seed
   p_seed_after_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (pat_i == SEED && !eop_i));

   // R3: an enabled first-phase clock never changes the vector
   p_hold_pair_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_en_i && !phase_i && HALF_RATE) |=> $stable(pat_i));

   // R5: marker is followed by the seed on the next enabled clock
   p_eop_wraps_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      eop_i |=> (pat_i == SEED));

   // R5: marker lasts one clock
   p_eop_single_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      eop_i |=> !eop_i);

   // R6: stalled clock holds vector and phase
   p_freeze_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_en_i |=> ($stable(pat_i) && $stable(phase_i)));

   // R6: no marker while stalled
   p_no_eop_stalled_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_en_i |-> !eop_i);

   // R7: valid follows the enable
   p_valid_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      pat_vld_i == run_en_i);

   // R8: never all zero
   p_nonzero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      pat_i != '0);

endmodule

bind halfrate_lfsr_tpg halfrate_lfsr_tpg_chk #(
   .WIDTH     (WIDTH),
   .SEED      (SEED),
   .HALF_RATE (HALF_RATE)
) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .run_en_i  (run_en_i),
   .pat_i     (pat_o),
   .pat_vld_i (pat_vld_o),
   .eop_i     (eop_o),
   .phase_i   (phase)
);

// File: tb/halfrate_lfsr_tpg_tb.sv
module halfrate_lfsr_tpg_tb;

   typedef struct packed {
      logic [2:0] pat;
      logic       eop;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       run_en = 1'b0;
   logic [2:0] pat;
   logic       pat_vld;
   logic       eop;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   exp_t sb_q[$];

   // bench model
   logic [2:0] m_state = 3'b100;
   bit         m_phase = 1'b0;
   int         m_pos   = 0;

   bit log_en = 1'b0;
   int hist[8];

   always #10 clk = ~clk;

   halfrate_lfsr_tpg u_dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .run_en_i  (run_en),
      .pat_o     (pat),
      .pat_vld_o (pat_vld),
      .eop_o     (eop)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] m_next(input logic [2:0] s);
      return {s[1], s[0], s[2] ^ s[1]};
   endfunction

   task automatic model_reset();
      m_state = 3'b100;
      m_phase = 1'b0;
      m_pos   = 0;
   endtask

   // driver: one clock, pushes the expected sample when enabled
   task automatic drive_cycle(input bit run);
      exp_t e;
      @(posedge clk);
      #1;
      run_en = run;
      if (run) begin
         e.pat = m_state;
         e.eop = (m_pos == 13);
         sb_q.push_back(e);
         if (m_phase) m_state = m_next(m_state);
         m_phase = ~m_phase;
         m_pos   = (m_pos == 13) ? 0 : m_pos + 1;
      end
   endtask

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst = 1'b1;
      run_en = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b0;
      model_reset();
      @(negedge clk);
      check(pat == 3'b100, "R1", "seed after reset", pat, 3'b100);
      check(eop == 1'b0, "R1", "eop after reset", eop, 0);
      check(pat_vld == 1'b0, "R7", "valid with run low", pat_vld, 0);
   endtask

   // stall n clocks, judging the hold at the ports
   task automatic stall_check(input int n);
      logic [2:0] snap;
      drive_cycle(1'b0);
      @(negedge clk);
      snap = pat;
      for (int i = 0; i < n; i++) begin
         drive_cycle(1'b0);
         @(negedge clk);
         check(pat == snap, "R6", "pattern held while stalled", pat, snap);
         check(eop == 1'b0, "R6", "eop low while stalled", eop, 0);
         check(pat_vld == 1'b0, "R7", "valid low while stalled", pat_vld, 0);
      end
   endtask

   // monitor: pops and compares every consumed sample
   always @(negedge clk) begin
      if (!rst) begin
         check(pat != 3'b000, "R8", "pattern non-zero", pat, 1);
         if (pat_vld) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R2", "unexpected sample", pat, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(pat == e.pat, "R2/R3", "sampled vector", pat, e.pat);
               check(eop == e.eop, "R5", "end-of-period marker", eop, e.eop);
            end
            if (log_en) hist[pat]++;
         end else begin
            check(eop == 1'b0, "R5", "eop without valid", eop, 0);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: state during and after reset
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(pat_vld == 1'b0, "R7", "valid low in reset", pat_vld, 0);
      do_reset();

      // R4: one full period, histogram of vectors
      for (int i = 0; i < 8; i++) hist[i] = 0;
      log_en = 1'b1;
      for (int i = 0; i < 14; i++) drive_cycle(1'b1);
      drive_cycle(1'b0);
      @(negedge clk);
      log_en = 1'b0;
      check(hist[0] == 0, "R4", "zero vector count", hist[0], 0);
      for (int v = 1; v < 8; v++)
         check(hist[v] == 2, "R4", "per-vector count", hist[v], 2);

      // R2, R3, R5: several periods in a row
      for (int i = 0; i < 40; i++) drive_cycle(1'b1);

      // R6: stall on a first-phase clock and on a second-phase clock
      if (!m_phase) drive_cycle(1'b1);
      stall_check(3);
      for (int i = 0; i < 5; i++) drive_cycle(1'b1);
      stall_check(4);
      for (int i = 0; i < 6; i++) drive_cycle(1'b1);

      // R5/R6: enable falls on the last position of a period
      while (m_pos != 13) drive_cycle(1'b1);
      stall_check(5);
      for (int i = 0; i < 6; i++) drive_cycle(1'b1);

      // irregular enable pattern
      for (int i = 0; i < 60; i++) drive_cycle((i % 3) != 1);

      // R1/R3: reset on a second-phase clock, seed held two samples
      while (!m_phase) drive_cycle(1'b1);
      do_reset();
      for (int i = 0; i < 20; i++) drive_cycle(1'b1);

      drive_cycle(1'b0);
      @(negedge clk);
      check(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule